// File: doc/BRIEF.md
# Tiered Sensor Protection Controller

This block watches six sampled sensor channels and escalates through three protective actions as readings climb. Each channel carries an unsigned 32-bit reading with a valid strobe, in fixed units: milliwatts for the two input-power channels, milliamps for the core-rail current, and tenths of a degree Celsius for the three temperature channels. Every channel has up to three limits, called tiers: a throttle tier, a clock-stop tier and a power-off tier. Some channels lack one or more tiers. All limits and the tier-presence map are parameters.

The throttle request is a level. It tracks the most recent readings and clears as soon as no channel sits at or above its throttle limit. The clock-stop request latches, raises a one-cycle firewall-trip pulse when it is first entered, and clears on a soft reset command. The power-off request latches and clears only on power-on reset. A sticky status vector records which channel crossed which tier. Software clears it with a write-one-to-clear mask. The power-off bits ignore that mask.

Channel order (index s): 0 = 12 V input power, 1 = 3.3 V input power, 2 = core-rail current, 3 = core-rail temperature, 4 = peak device/memory temperature, 5 = optical-module temperature. Tier order (index t): 0 = throttle, 1 = clock-stop, 2 = power-off.

Top module: `sensor_guard`

## Requirements
- R1: A tier counts as crossed when the held reading is greater than or equal to its limit. Default limits (throttle/clock-stop/power-off, "-" = absent): ch0 62000/65000/-, ch1 9900/11000/-, ch2 56000/-/60000, ch3 1050/1100/1250, ch4 920/970/1070, ch5 -/850/900.
- R2: An absent tier never sets its status bit and never drives an output, whatever the reading.
- R3: `throttleReq` is high while any channel's held reading is at or above its throttle limit. It drops once every such reading is below its limit. It changes in the cycle after the edge that captures the reading.
- R4: A reading is captured only on an edge where its `sensorValid` bit is high. Between strobes the last captured value is kept, and data presented without valid has no effect.
- R5: A captured reading at or above a clock-stop limit sets `clkStopReq` one edge after capture. It stays set until an edge with `softResetCmd` high and no new clock-stop crossing on that edge.
- R6: `firewallTrip` is a one-cycle pulse. It is asserted together with the rise of `clkStopReq` and never while the clock-stop state was already held.
- R7: A captured reading at or above a power-off limit sets `powerOffReq` one edge after capture, without a firewall pulse. Only `rstPorN` low clears it. `softResetCmd` leaves it set.
- R8: `statusBits[s*3+t]` is set one edge after a captured reading on channel s crosses tier t. It stays set until an edge where the matching `statusClearMask` bit is 1. Power-off bits (t = 2) ignore the mask.
- R9: While `clkStopReq` or `powerOffReq` is high, `throttleReq` is high.
- R10: One sample crossing several tiers sets every crossed tier's status bit and output in the same cycle.
- R11: During and after power-on reset, all outputs and status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstPorN | input | 1 | Synchronous power-on reset, active low |
| softResetCmd | input | 1 | Soft reset command; clears the clock-stop state |
| sensorValid | input | 6 | Per-channel capture strobe |
| sensorData | input | 192 | Channel s reading at bits [s*32 +: 32] |
| statusClearMask | input | 18 | Write-one-to-clear mask for the status bits |
| throttleReq | output | 1 | Clock throttle request (level) |
| clkStopReq | output | 1 | Kernel clock stop request (latched) |
| firewallTrip | output | 1 | One-cycle pulse on entry into clock stop |
| powerOffReq | output | 1 | Device power removal request (latched) |
| statusBits | output | 18 | Sticky per-channel, per-tier crossing record |

## Verification
The bench tests readings exactly at each limit and one count below it. A design using a strict greater-than comparison would miss the at-limit case. It drives high readings into channels whose middle or lowest tier is absent; a design that ignores the presence map would stop the clocks or throttle there. It issues a second clock-stop crossing while already stopped, which would produce a repeated firewall pulse. It then issues a soft reset and a status clear during power-off; a design that clears the wrong latch or bits would drop `powerOffReq` or its status bits.

// File: rtl/sensor_guard_pkg.sv
package sensor_guard_pkg;
  localparam int NUM_SENSORS = 6;
  localparam int NUM_TIERS   = 3;
  localparam int READING_W   = 32;
  localparam int STATUS_W    = NUM_SENSORS * NUM_TIERS;

  localparam int TIER_THROTTLE = 0;
  localparam int TIER_STOP     = 1;
  localparam int TIER_OFF      = 2;

  typedef logic [NUM_SENSORS-1:0][NUM_TIERS-1:0] tier_map_t;
  typedef logic [NUM_SENSORS-1:0][NUM_TIERS-1:0][READING_W-1:0] limit_table_t;

  // Strobes from the comparison datapath to the escalation control
  typedef struct packed {
    logic [NUM_SENSORS-1:0] throttleLevel;
    tier_map_t              sampleHit;
  } hit_strobes_t;

  function automatic limit_table_t default_limits();
    limit_table_t tbl = '0;
    tbl[0][TIER_THROTTLE] = 62000;  tbl[0][TIER_STOP] = 65000;
    tbl[1][TIER_THROTTLE] = 9900;   tbl[1][TIER_STOP] = 11000;
    tbl[2][TIER_THROTTLE] = 56000;  tbl[2][TIER_OFF]  = 60000;
    tbl[3][TIER_THROTTLE] = 1050;   tbl[3][TIER_STOP] = 1100;  tbl[3][TIER_OFF] = 1250;
    tbl[4][TIER_THROTTLE] = 920;    tbl[4][TIER_STOP] = 970;   tbl[4][TIER_OFF] = 1070;
    tbl[5][TIER_STOP]     = 850;    tbl[5][TIER_OFF]  = 900;
    return tbl;
  endfunction

  function automatic tier_map_t default_present();
    tier_map_t m = '1;
    m[0][TIER_OFF]      = 1'b0;
    m[1][TIER_OFF]      = 1'b0;
    m[2][TIER_STOP]     = 1'b0;
    m[5][TIER_THROTTLE] = 1'b0;
    return m;
  endfunction

  function automatic tier_map_t tier_column(input int tier);
    tier_map_t m = '0;
    for (int s = 0; s < NUM_SENSORS; s++) m[s][tier] = 1'b1;
    return m;
  endfunction

  localparam limit_table_t DEFAULT_LIMITS  = default_limits();
  localparam tier_map_t    DEFAULT_PRESENT = default_present();
endpackage

// File: rtl/sensor_guard_datapath.sv
module sensor_guard_datapath
  import sensor_guard_pkg::*;
#(
  parameter limit_table_t LIMITS  = DEFAULT_LIMITS,
  parameter tier_map_t    PRESENT = DEFAULT_PRESENT
) (
  input  logic                           clk,
  input  logic                           rstPorN,
  input  logic [NUM_SENSORS-1:0]         sensorValid,
  input  logic [NUM_SENSORS*READING_W-1:0] sensorData,
  output hit_strobes_t                   hits
);
  logic [READING_W-1:0]   heldReading [NUM_SENSORS];
  logic [NUM_SENSORS-1:0] fresh;
  tier_map_t              levelHit;
  tier_map_t              sampleHit;
  logic [NUM_SENSORS-1:0] throttleLevel;

  for (genvar s = 0; s < NUM_SENSORS; s++) begin : g_sensor
    always_ff @(posedge clk) begin
      if (!rstPorN) begin
        heldReading[s] <= '0;
        fresh[s]       <= 1'b0;
      end else begin
        fresh[s] <= sensorValid[s];
        if (sensorValid[s]) heldReading[s] <= sensorData[s*READING_W +: READING_W];
      end
    end

    for (genvar t = 0; t < NUM_TIERS; t++) begin : g_tier
      if (PRESENT[s][t]) begin : g_cmp
        assign levelHit[s][t] = (heldReading[s] >= LIMITS[s][t]);
      end else begin : g_absent
        assign levelHit[s][t] = 1'b0;
      end
      assign sampleHit[s][t] = levelHit[s][t] & fresh[s];
    end

    assign throttleLevel[s] = levelHit[s][TIER_THROTTLE];
  end

  assign hits.throttleLevel = throttleLevel;
  assign hits.sampleHit     = sampleHit;
endmodule

// File: rtl/sensor_guard_control.sv
module sensor_guard_control
  import sensor_guard_pkg::*;
(
  input  logic                clk,
  input  logic                rstPorN,
  input  logic                softResetCmd,
  input  logic [STATUS_W-1:0] statusClearMask,
  input  hit_strobes_t        hits,
  output logic                throttleReq,
  output logic                clkStopReq,
  output logic                firewallTrip,
  output logic                powerOffReq,
  output logic [STATUS_W-1:0] statusBits
);
  localparam tier_map_t CLEARABLE = ~tier_column(TIER_OFF);

  logic [NUM_SENSORS-1:0] stopCol, offCol;
  logic      stopEvent, offEvent;
  logic      stopLatch, offLatch, tripPulse;
  tier_map_t sticky;

  for (genvar s = 0; s < NUM_SENSORS; s++) begin : g_col
    assign stopCol[s] = hits.sampleHit[s][TIER_STOP];
    assign offCol[s]  = hits.sampleHit[s][TIER_OFF];
  end

  assign stopEvent = |stopCol;
  assign offEvent  = |offCol;

  always_ff @(posedge clk) begin
    if (!rstPorN) begin
      sticky    <= '0;
      stopLatch <= 1'b0;
      tripPulse <= 1'b0;
      offLatch  <= 1'b0;
    end else begin
      sticky    <= (sticky & ~(tier_map_t'(statusClearMask) & CLEARABLE)) | hits.sampleHit;
      stopLatch <= stopEvent | (stopLatch & ~softResetCmd);
      tripPulse <= stopEvent & ~stopLatch;
      offLatch  <= offLatch | offEvent;
    end
  end

  assign throttleReq  = (|hits.throttleLevel) | stopLatch | offLatch;
  assign clkStopReq   = stopLatch;
  assign firewallTrip = tripPulse;
  assign powerOffReq  = offLatch;
  assign statusBits   = sticky;
endmodule

// File: rtl/sensor_guard.sv
module sensor_guard
  import sensor_guard_pkg::*;
#(
  parameter limit_table_t LIMITS  = DEFAULT_LIMITS,
  parameter tier_map_t    PRESENT = DEFAULT_PRESENT
) (
  input  logic                             clk,
  input  logic                             rstPorN,
  input  logic                             softResetCmd,
  input  logic [NUM_SENSORS-1:0]           sensorValid,
  input  logic [NUM_SENSORS*READING_W-1:0] sensorData,
  input  logic [STATUS_W-1:0]              statusClearMask,
  output logic                             throttleReq,
  output logic                             clkStopReq,
  output logic                             firewallTrip,
  output logic                             powerOffReq,
  output logic [STATUS_W-1:0]              statusBits
);
  hit_strobes_t hits;

  sensor_guard_datapath #(.LIMITS(LIMITS), .PRESENT(PRESENT)) u_datapath (
    .clk         (clk),
    .rstPorN     (rstPorN),
    .sensorValid (sensorValid),
    .sensorData  (sensorData),
    .hits        (hits)
  );

  sensor_guard_control u_control (
    .clk             (clk),
    .rstPorN         (rstPorN),
    .softResetCmd    (softResetCmd),
    .statusClearMask (statusClearMask),
    .hits            (hits),
    .throttleReq     (throttleReq),
    .clkStopReq      (clkStopReq),
    .firewallTrip    (firewallTrip),
    .powerOffReq     (powerOffReq),
    .statusBits      (statusBits)
  );
endmodule

// File: rtl/sensor_guard_checker.sv
module sensor_guard_checker
  import sensor_guard_pkg::*;
#(
  parameter tier_map_t PRESENT = DEFAULT_PRESENT
) (
  input logic                clk,
  input logic                rstPorN,
  input logic                softResetCmd,
  input logic                throttleReq,
  input logic                clkStopReq,
  input logic                firewallTrip,
  input logic                powerOffReq,
  input logic [STATUS_W-1:0] statusBits
);
  localparam logic [STATUS_W-1:0] OFF_BITS    = tier_column(TIER_OFF);
  localparam logic [STATUS_W-1:0] ABSENT_BITS = ~PRESENT;

  assert_absent_silent_R2: assert property (@(posedge clk) disable iff (!rstPorN)
    (statusBits & ABSENT_BITS) == '0);

  assert_stop_hold_R5: assert property (@(posedge clk) disable iff (!rstPorN)
    (clkStopReq && !softResetCmd) |=> clkStopReq);

  assert_trip_single_R6: assert property (@(posedge clk) disable iff (!rstPorN)
    firewallTrip |=> !firewallTrip);

  assert_trip_on_entry_R6: assert property (@(posedge clk) disable iff (!rstPorN)
    firewallTrip |-> (clkStopReq && !$past(clkStopReq)));

  assert_off_hold_R7: assert property (@(posedge clk) disable iff (!rstPorN)
    powerOffReq |=> powerOffReq);

  assert_off_bits_keep_R8: assert property (@(posedge clk) disable iff (!rstPorN)
    ((statusBits & OFF_BITS) & $past(statusBits & OFF_BITS)) == $past(statusBits & OFF_BITS));

  assert_throttle_forced_R9: assert property (@(posedge clk) disable iff (!rstPorN)
    (clkStopReq || powerOffReq) |-> throttleReq);
endmodule

bind sensor_guard sensor_guard_checker #(.PRESENT(PRESENT)) u_checker (
  .clk          (clk),
  .rstPorN      (rstPorN),
  .softResetCmd (softResetCmd),
  .throttleReq  (throttleReq),
  .clkStopReq   (clkStopReq),
  .firewallTrip (firewallTrip),
  .powerOffReq  (powerOffReq),
  .statusBits   (statusBits)
);

// File: tb/sensor_guard_test.sv
`timescale 1ns/100ps
module sensor_guard_test;
  import sensor_guard_pkg::*;

  logic                             clk = 1'b0;
  logic                             rstPorN = 1'b0;
  logic                             softResetCmd = 1'b0;
  logic [NUM_SENSORS-1:0]           sensorValid = '0;
  logic [NUM_SENSORS*READING_W-1:0] sensorData = '0;
  logic [STATUS_W-1:0]              statusClearMask = '0;
  logic                             throttleReq, clkStopReq, firewallTrip, powerOffReq;
  logic [STATUS_W-1:0]              statusBits;

  int  checkCount = 0;
  int  failCount  = 0;
  bit  done       = 1'b0;

  always #2.5 clk = ~clk;

  sensor_guard uut (
    .clk(clk), .rstPorN(rstPorN), .softResetCmd(softResetCmd),
    .sensorValid(sensorValid), .sensorData(sensorData),
    .statusClearMask(statusClearMask),
    .throttleReq(throttleReq), .clkStopReq(clkStopReq),
    .firewallTrip(firewallTrip), .powerOffReq(powerOffReq),
    .statusBits(statusBits)
  );

  task automatic check(input string req, input logic [31:0] actual, input logic [31:0] expected);
    checkCount++;
    if (actual !== expected) begin
      failCount++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Drive one valid sample; returns at the negedge after the capture edge.
  task automatic sample(input int s, input logic [31:0] value);
    sensorValid[s] = 1'b1;
    sensorData[s*READING_W +: READING_W] = value;
    tick();
    sensorValid[s] = 1'b0;
  endtask

  task automatic por();
    rstPorN = 1'b0;
    tick(); tick();
    rstPorN = 1'b1;
    tick();
  endtask

  task automatic soft_reset();
    softResetCmd = 1'b1; tick(); softResetCmd = 1'b0;
  endtask

  task automatic clear_status(input logic [STATUS_W-1:0] mask);
    statusClearMask = mask; tick(); statusClearMask = '0;
  endtask

  task automatic t_reset();
    check("R11 throttle", throttleReq, 0);
    check("R11 clkStop", clkStopReq, 0);
    check("R11 trip", firewallTrip, 0);
    check("R11 powerOff", powerOffReq, 0);
    check("R11 status", statusBits, 0);
  endtask

  task automatic t_threshold_edge();
    sample(0, 61999);
    check("R1 one below limit no throttle", throttleReq, 0);
    tick();
    check("R1 one below limit no status", statusBits, 0);
    sample(0, 62000);
    check("R1 at limit throttles", throttleReq, 1);
    tick();
    check("R8 status bit0 set", statusBits, 32'h1);
    check("R1 clock-stop not reached", clkStopReq, 0);
    sensorData[0 +: READING_W] = 0;
    tick(); tick();
    check("R4 data without valid ignored", throttleReq, 1);
    sample(0, 61000);
    check("R3 throttle drops when below", throttleReq, 0);
    check("R8 status sticky after drop", statusBits, 32'h1);
    clear_status(18'h1);
    check("R8 w1c clears bit0", statusBits, 0);
  endtask

  task automatic t_throttle_multi();
    sample(3, 1050);
    sample(4, 920);
    check("R3 two channels throttle", throttleReq, 1);
    sample(3, 1000);
    check("R3 one channel still high", throttleReq, 1);
    sample(4, 919);
    check("R3 all below releases", throttleReq, 0);
    clear_status('1);
  endtask

  task automatic t_clock_stop();
    sample(4, 970);
    check("R5 not yet latched at capture", clkStopReq, 0);
    tick();
    check("R5 clock stop latched", clkStopReq, 1);
    check("R6 trip pulse", firewallTrip, 1);
    check("R8 bits 12 and 13", statusBits, 32'h3000);
    tick();
    check("R6 trip one cycle", firewallTrip, 0);
    sample(4, 0);
    repeat (4) tick();
    check("R5 stop holds", clkStopReq, 1);
    check("R9 throttle forced by stop", throttleReq, 1);
    sample(1, 11000);
    tick();
    check("R6 no second trip", firewallTrip, 0);
    check("R8 bit4 set", statusBits[4], 1);
    sample(1, 0);
    soft_reset();
    check("R5 soft reset clears stop", clkStopReq, 0);
    check("R3 throttle released after stop", throttleReq, 0);
    clear_status('1);
  endtask

  task automatic t_absent();
    sample(2, 58000);
    check("R3 core current throttles", throttleReq, 1);
    tick();
    check("R2 absent clock-stop tier silent", clkStopReq, 0);
    check("R2 status only bit6", statusBits, 32'h40);
    sample(2, 0);
    clear_status('1);
  endtask

  task automatic t_power_off();
    sample(2, 60000);
    tick();
    check("R7 power-off latched", powerOffReq, 1);
    check("R7 no trip on power-off", firewallTrip, 0);
    check("R2 no clock stop for ch2", clkStopReq, 0);
    check("R9 throttle forced by off", throttleReq, 1);
    soft_reset();
    check("R7 soft reset keeps power-off", powerOffReq, 1);
    clear_status('1);
    check("R8 power-off bit survives clear", statusBits, 32'h100);
    por();
    check("R7 por clears power-off", powerOffReq, 0);
    check("R11 por clears status", statusBits, 0);
  endtask

  task automatic t_multi();
    sample(3, 1250);
    tick();
    check("R10 all three tiers ch3", statusBits, 32'hE00);
    check("R10 stop set", clkStopReq, 1);
    check("R10 off set", powerOffReq, 1);
    check("R10 trip", firewallTrip, 1);
    sample(5, 32'hFFFF_FFFF);
    tick();
    check("R2 ch5 throttle bit never set", statusBits[15], 0);
    check("R10 ch5 stop and off bits", statusBits[17:16], 2'b11);
    check("R6 no trip when already stopped", firewallTrip, 0);
    por();
    check("R11 clean after por", {throttleReq, clkStopReq, powerOffReq}, 0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  endtask

  initial begin
    tick(); tick();
    t_reset();
    rstPorN = 1'b1;
    tick();
    t_reset();
    t_threshold_edge();
    t_throttle_multi();
    t_clock_stop();
    t_absent();
    t_power_off();
    t_multi();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end
endmodule